// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block arbitrates among a parameterised set of interrupt request lines (16 by default) and tracks which handlers are running so that they can nest. Each line has an enable, a pending flag and a 4-bit urgency value. A global grouping setting divides that value into a preemption field in the upper bits and a subpriority field in the lower bits. Only the preemption field decides whether a request may interrupt a running handler. The full value decides the order among requests that are pending at the same time.

A processor-side agent sees `irq_valid` together with the candidate `irq_vec`. It accepts a candidate by raising `irq_ack`. One cycle later the block pulses `take_stb` with the accepted line on `take_vec`, clears that line's pending flag, marks it active and pushes its preemption level onto an internal level stack. A `ret_stb` pulse pops the stack, which restores the level of the interrupted handler or of thread mode. Configuration uses a single write port that carries a kind code. Lines in the lower half of the index range are level-sensitive. Lines in the upper half latch rising edges. The `PULSE_LINES` parameter can change this split.

Top module: `irq_nest_arb`

## Requirements
- R1: A priority write (`cfg_kind`=1) stores `cfg_data[7:4]` as the line's urgency value and ignores `cfg_data[3:0]`. A numerically lower value is more urgent.
- R2: A group write (`cfg_kind`=2) with a value from 0 to 4 sets how many upper bits of the urgency value form the preemption field: 0, 1, 2, 3 or 4 bits. A group write with any value above 4 leaves the setting unchanged.
- R3: An enable write (`cfg_kind`=0) sets the line's enable to `cfg_data[0]`. A disabled line still latches pending, but it is never offered on `irq_vec` and never raises `irq_valid`.
- R4: Among enabled pending lines, the one with the lowest urgency value is the candidate. The preemption field orders first and the subpriority field second. On a full tie the lowest line index wins.
- R5: `irq_valid` is high only when the candidate's preemption field, with the subpriority bits zeroed, is strictly lower than `cur_level`. `cur_level` is 16 with no handler active, so in thread mode any candidate qualifies. A candidate with an equal preemption field does not nest, whatever its subpriority.
- R6: If `irq_valid` and `irq_ack` are both high at a clock edge, then during the next cycle `take_stb` is high for one cycle and `take_vec` holds the line. In that same cycle the line is active, its pending bit is clear, and `nest_depth` has grown by one.
- R7: A `ret_stb` pulse while `nest_depth` is above zero pops the top entry, clears the active bit of its line, and restores `cur_level` to the level below it, or to 16.
- R8: A level line sets pending on every cycle its input is high. A pulse line sets pending only on a rising edge. A clear write (`cfg_kind`=3) zeroes pending, but a set in the same cycle wins over it. A line left pending is offered again once the handler that blocked it returns.
- R9: A `ret_stb` with `nest_depth` at 0, or a take with `nest_depth` at `NEST_DEPTH` (4), sets the sticky `stk_err` flag and leaves the stack as it was. A take that overflows still strobes and marks its line active.
- R10: After reset all lines are disabled, not pending and inactive, every urgency value is 0, the group is 0, `cur_level` is 16, `nest_depth` is 0 and `stk_err` is low.
- R11: While `ret_stb` is high, `irq_valid` is low, so an `irq_ack` in that cycle takes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 enable, 1 priority, 2 group, 3 clear pending |
| cfg_line | input | $clog2(N) | Target line of the write |
| cfg_data | input | 8 | Write data |
| irq_req | input | N | Request inputs |
| irq_valid | output | 1 | A candidate may preempt the current level |
| irq_vec | output | $clog2(N) | Candidate line index |
| irq_ack | input | 1 | Accept the candidate |
| take_stb | output | 1 | One-cycle strobe after an accepted take |
| take_vec | output | $clog2(N) | Line taken |
| ret_stb | input | 1 | Handler return |
| cur_level | output | 5 | Current preemption level, 16 in thread mode |
| nest_depth | output | $clog2(NEST_DEPTH+1) | Number of stacked handlers |
| active | output | N | Lines currently marked active |
| pending | output | N | Pending flags |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The bench targets these corner cases:
- A request with an equal preemption field but a better subpriority must not nest. A design that compares the whole value would nest it.
- A request that depends on the group setting must keep its outcome after an illegal group write. A design that accepts values above 4 would change it.
- A level line held high across its own take must stay pending and be offered again after return. A design that lets the take clear win would drop it.
- A return and an acknowledge in the same cycle must take nothing.
- A fifth nested take and a return from thread mode must both set the sticky error without corrupting the restored levels. Wrong stack indexing would show here as a wrong `cur_level` after the returns.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int PRIO_W = 4;
  localparam int LVL_W  = PRIO_W + 1;
  localparam logic [LVL_W-1:0] THREAD_LVL = 5'd16;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_PRIO   = 2'd1,
    CFG_GROUP  = 2'd2,
    CFG_CLEAR  = 2'd3
  } cfg_kind_e;

  // Bits of the urgency value that form the preemption field for a group.
  function automatic logic [PRIO_W-1:0] preempt_mask(input logic [2:0] grp);
    case (grp)
      3'd0:    return 4'b0000;
      3'd1:    return 4'b1000;
      3'd2:    return 4'b1100;
      3'd3:    return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  // Preemption level of a value: subpriority bits zeroed, widened so the
  // thread level (16) sits above every handler level.
  function automatic logic [LVL_W-1:0] preempt_level(input logic [PRIO_W-1:0] nib,
                                                     input logic [2:0] grp);
    return {1'b0, nib & preempt_mask(grp)};
  endfunction

  function automatic logic group_legal(input logic [7:0] val);
    return val <= 8'd4;
  endfunction
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
  parameter int N = 16,
  parameter logic [N-1:0] PULSE_LINES = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             req_in,
  input  logic                     en_wr,
  input  logic                     prio_wr,
  input  logic                     clr_wr,
  input  logic [$clog2(N)-1:0]     cfg_line,
  input  logic                     en_bit,
  input  logic [3:0]               prio_nib,
  input  logic                     take_hit,
  input  logic [$clog2(N)-1:0]     take_line,
  output logic [N-1:0]             pend,
  output logic [N-1:0]             enab,
  output logic [N-1:0][3:0]        prio,
  output logic [N-1:0]             set_evt
);
  localparam int LW = $clog2(N);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic sel;
    logic taken;
    assign sel   = (cfg_line == LW'(g));
    assign taken = take_hit && (take_line == LW'(g));

    if (PULSE_LINES[g]) begin : g_pulse
      logic req_d;
      always_ff @(posedge clk) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= req_in[g];
      end
      assign set_evt[g] = req_in[g] & ~req_d;
    end else begin : g_level
      assign set_evt[g] = req_in[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        enab[g] <= 1'b0;
        prio[g] <= '0;
      end else begin
        if (set_evt[g])                 pend[g] <= 1'b1;
        else if ((clr_wr && sel) || taken) pend[g] <= 1'b0;
        if (en_wr && sel)   enab[g] <= en_bit;
        if (prio_wr && sel) prio[g] <= prio_nib;
      end
    end
  end
endmodule

// File: rtl/irq_win_pick.sv
module irq_win_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0]          elig,
  input  logic [N-1:0][3:0]     prio,
  output logic                  found,
  output logic [$clog2(N)-1:0]  idx,
  output logic [3:0]            nib
);
  localparam int LW = $clog2(N);

  // Whole value compares preemption then subpriority; strict "<" keeps
  // the lowest index on a tie.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    nib   = 4'hF;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || (prio[i] < nib))) begin
        found = 1'b1;
        idx   = LW'(i);
        nib   = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_nest_pkg::*;
#(
  parameter int N     = 16,
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [LVL_W-1:0]            push_lvl,
  input  logic [$clog2(N)-1:0]        push_line,
  input  logic                        pop,
  output logic [LVL_W-1:0]            cur_lvl,
  output logic [$clog2(DEPTH+1)-1:0]  depth,
  output logic [N-1:0]                active,
  output logic                        err,
  output logic                        push_over,
  output logic                        pop_under
);
  localparam int LW = $clog2(N);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVL_W-1:0] lvl_mem  [DEPTH];
  logic [LW-1:0]    line_mem [DEPTH];
  logic [SW-1:0]    top_idx;
  logic [SW-1:0]    put_idx;
  logic             empty;
  logic             full;

  assign empty     = (depth == '0);
  assign full      = (depth == DW'(DEPTH));
  assign top_idx   = SW'(depth - 1'b1);
  assign put_idx   = SW'(depth);
  assign cur_lvl   = empty ? THREAD_LVL : lvl_mem[top_idx];
  assign push_over = push && !pop && full;
  assign pop_under = pop && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth  <= '0;
      active <= '0;
      err    <= 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
        lvl_mem[k]  <= '0;
        line_mem[k] <= '0;
      end
    end else if (pop) begin
      if (empty) begin
        err <= 1'b1;
      end else begin
        active[line_mem[top_idx]] <= 1'b0;
        depth <= depth - 1'b1;
      end
    end else if (push) begin
      active[push_line] <= 1'b1;
      if (full) begin
        err <= 1'b1;
      end else begin
        lvl_mem[put_idx]  <= push_lvl;
        line_mem[put_idx] <= push_line;
        depth <= depth + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int N          = 16,
  parameter int NEST_DEPTH = 4,
  parameter logic [N-1:0] PULSE_LINES = {N{1'b1}} << (N / 2)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [1:0]                       cfg_kind,
  input  logic [$clog2(N)-1:0]             cfg_line,
  input  logic [7:0]                       cfg_data,
  input  logic [N-1:0]                     irq_req,
  output logic                             irq_valid,
  output logic [$clog2(N)-1:0]             irq_vec,
  input  logic                             irq_ack,
  output logic                             take_stb,
  output logic [$clog2(N)-1:0]             take_vec,
  input  logic                             ret_stb,
  output logic [4:0]                       cur_level,
  output logic [$clog2(NEST_DEPTH+1)-1:0]  nest_depth,
  output logic [N-1:0]                     active,
  output logic [N-1:0]                     pending,
  output logic                             stk_err
);
  localparam int LW = $clog2(N);

  cfg_kind_e          kind;
  logic [2:0]         grp_q;
  logic [N-1:0]       enab;
  logic [N-1:0][3:0]  prio;
  logic [N-1:0]       set_evt;
  logic               win_found;
  logic [LW-1:0]      win_idx;
  logic [3:0]         win_nib;
  logic [LVL_W-1:0]   cand_lvl;
  logic               take_fire;
  logic               push_over;
  logic               pop_under;

  assign kind = cfg_kind_e'(cfg_kind);

  irq_line_bank #(.N(N), .PULSE_LINES(PULSE_LINES)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (irq_req),
    .en_wr     (cfg_we && kind == CFG_ENABLE),
    .prio_wr   (cfg_we && kind == CFG_PRIO),
    .clr_wr    (cfg_we && kind == CFG_CLEAR),
    .cfg_line  (cfg_line),
    .en_bit    (cfg_data[0]),
    .prio_nib  (cfg_data[7:4]),
    .take_hit  (take_fire),
    .take_line (win_idx),
    .pend      (pending),
    .enab      (enab),
    .prio      (prio),
    .set_evt   (set_evt)
  );

  irq_win_pick #(.N(N)) pick_i (
    .elig  (pending & enab),
    .prio  (prio),
    .found (win_found),
    .idx   (win_idx),
    .nib   (win_nib)
  );

  assign cand_lvl  = preempt_level(win_nib, grp_q);
  assign irq_valid = win_found && (cand_lvl < cur_level) && !ret_stb;
  assign irq_vec   = win_idx;
  assign take_fire = irq_valid && irq_ack;

  irq_lvl_stack #(.N(N), .DEPTH(NEST_DEPTH)) stack_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (take_fire),
    .push_lvl  (cand_lvl),
    .push_line (win_idx),
    .pop       (ret_stb),
    .cur_lvl   (cur_level),
    .depth     (nest_depth),
    .active    (active),
    .err       (stk_err),
    .push_over (push_over),
    .pop_under (pop_under)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q    <= '0;
      take_stb <= 1'b0;
      take_vec <= '0;
    end else begin
      if (cfg_we && kind == CFG_GROUP && group_legal(cfg_data))
        grp_q <= cfg_data[2:0];
      take_stb <= take_fire;
      if (take_fire) take_vec <= win_idx;
    end
  end
endmodule

// File: rtl/irq_nest_arb_chk.sv
module irq_nest_arb_chk #(
  parameter int N          = 16,
  parameter int NEST_DEPTH = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             irq_valid,
  input logic [$clog2(N)-1:0]             irq_vec,
  input logic                             irq_ack,
  input logic                             take_stb,
  input logic [$clog2(N)-1:0]             take_vec,
  input logic                             ret_stb,
  input logic [4:0]                       cur_level,
  input logic [$clog2(NEST_DEPTH+1)-1:0]  nest_depth,
  input logic [N-1:0]                     active,
  input logic [N-1:0]                     pending,
  input logic                             stk_err,
  input logic                             push_over,
  input logic                             pop_under
);
  localparam int DW = $clog2(NEST_DEPTH + 1);

  // R6: a strobe only follows an accepted candidate
  a_r6_take_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    take_stb |-> $past(irq_valid && irq_ack));

  // R6: the taken line is marked active
  a_r6_take_active: assert property (@(posedge clk) disable iff (!rst_n)
    take_stb |-> active[take_vec]);

  // R3: the offered candidate is pending
  a_r3_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> pending[irq_vec]);

  // R5: a stacked take always lowers the current level
  a_r5_level_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (take_stb && $past(nest_depth) < DW'(NEST_DEPTH)) |-> cur_level < $past(cur_level));

  // R7: a return from a handler removes one entry
  a_r7_pop_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb && nest_depth != '0) |=> nest_depth == DW'($past(nest_depth) - 1'b1));

  // R9: underflow and overflow raise the flag and keep the depth
  a_r9_under_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pop_under |=> (stk_err && nest_depth == '0));
  a_r9_over_flag: assert property (@(posedge clk) disable iff (!rst_n)
    push_over |=> (stk_err && $stable(nest_depth)));

  // R9: the error flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);
endmodule

bind irq_nest_arb irq_nest_arb_chk #(.N(N), .NEST_DEPTH(NEST_DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_valid  (irq_valid),
  .irq_vec    (irq_vec),
  .irq_ack    (irq_ack),
  .take_stb   (take_stb),
  .take_vec   (take_vec),
  .ret_stb    (ret_stb),
  .cur_level  (cur_level),
  .nest_depth (nest_depth),
  .active     (active),
  .pending    (pending),
  .stk_err    (stk_err),
  .push_over  (push_over),
  .pop_under  (pop_under)
);

// File: tb/irq_nest_arb_tb_top.sv
module irq_nest_arb_tb_top;
  localparam int N  = 16;
  localparam int ND = 4;
  localparam int CLK_PERIOD = 10;
  localparam logic [N-1:0] PULSE = 16'hFF00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic         cfg_we = 0;
  logic [1:0]   cfg_kind = 0;
  logic [3:0]   cfg_line = 0;
  logic [7:0]   cfg_data = 0;
  logic [N-1:0] irq_req = 0;
  logic         irq_ack = 0;
  logic         ret_stb = 0;
  logic         irq_valid, take_stb, stk_err;
  logic [3:0]   irq_vec, take_vec;
  logic [4:0]   cur_level;
  logic [2:0]   nest_depth;
  logic [N-1:0] active, pending;

  irq_nest_arb #(.N(N), .NEST_DEPTH(ND), .PULSE_LINES(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_line(cfg_line), .cfg_data(cfg_data), .irq_req(irq_req),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .take_stb(take_stb), .take_vec(take_vec), .ret_stb(ret_stb),
    .cur_level(cur_level), .nest_depth(nest_depth), .active(active),
    .pending(pending), .stk_err(stk_err));

  int checks = 0;
  int errors = 0;
  string phase = "R10";

  // behavioural reference state
  bit m_pend[N], m_en[N], m_act[N], m_prev[N];
  int m_prio[N];
  int m_grp;
  bit m_err, m_tstb;
  int m_tvec;
  int s_lvl[$];
  int s_line[$];

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", phase, what, act, exp);
    end
  endtask

  function automatic int lvl_of(int p, int g);
    if (g == 0) return 0;
    return (p >> (4 - g)) << (4 - g);
  endfunction

  function automatic int cur_of();
    return (s_lvl.size() == 0) ? 16 : s_lvl[$];
  endfunction

  task automatic model_comb(output bit v, output int w);
    int best_key;
    best_key = 1 << 30;
    w = -1;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_pend[i] && (m_prio[i] * N + i) < best_key) begin
        best_key = m_prio[i] * N + i;
        w = i;
      end
    v = (w >= 0) && (lvl_of(m_prio[w], m_grp) < cur_of()) && !ret_stb;
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_pend[i] = 0; m_en[i] = 0; m_act[i] = 0; m_prev[i] = 0; m_prio[i] = 0;
    end
    m_grp = 0; m_err = 0; m_tstb = 0; m_tvec = 0;
    s_lvl.delete(); s_line.delete();
  endtask

  task automatic model_step();
    bit v; int w; bit set;
    model_comb(v, w);
    if (ret_stb) begin
      if (s_lvl.size() == 0) m_err = 1;
      else begin
        m_act[s_line[$]] = 0;
        void'(s_lvl.pop_back());
        void'(s_line.pop_back());
      end
    end
    m_tstb = v && irq_ack;
    if (m_tstb) begin
      m_tvec = w; m_pend[w] = 0; m_act[w] = 1;
      if (s_lvl.size() < ND) begin
        s_lvl.push_back(lvl_of(m_prio[w], m_grp));
        s_line.push_back(w);
      end else m_err = 1;
    end
    if (cfg_we) begin
      case (cfg_kind)
        2'd0: m_en[cfg_line] = cfg_data[0];
        2'd1: m_prio[cfg_line] = int'(cfg_data) / 16;
        2'd2: if (cfg_data <= 8'd4) m_grp = int'(cfg_data);
        default: m_pend[cfg_line] = 0;
      endcase
    end
    for (int i = 0; i < N; i++) begin
      set = PULSE[i] ? (irq_req[i] && !m_prev[i]) : irq_req[i];
      if (set) m_pend[i] = 1;
      m_prev[i] = irq_req[i];
    end
  endtask

  task automatic compare();
    bit v; int w;
    logic [N-1:0] ep, ea;
    model_comb(v, w);
    for (int i = 0; i < N; i++) begin ep[i] = m_pend[i]; ea[i] = m_act[i]; end
    chk(irq_valid == v, "irq_valid", int'(irq_valid), int'(v));
    if (v) chk(int'(irq_vec) == w, "irq_vec", int'(irq_vec), w);
    chk(take_stb == m_tstb, "take_stb", int'(take_stb), int'(m_tstb));
    if (m_tstb) chk(int'(take_vec) == m_tvec, "take_vec", int'(take_vec), m_tvec);
    chk(int'(cur_level) == cur_of(), "cur_level", int'(cur_level), cur_of());
    chk(int'(nest_depth) == s_lvl.size(), "nest_depth", int'(nest_depth), s_lvl.size());
    chk(pending == ep, "pending", int'(pending), int'(ep));
    chk(active == ea, "active", int'(active), int'(ea));
    chk(stk_err == m_err, "stk_err", int'(stk_err), int'(m_err));
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic cfg(int kind, int line, int data);
    cfg_we = 1; cfg_kind = 2'(kind); cfg_line = 4'(line); cfg_data = 8'(data);
    tick();
    cfg_we = 0;
  endtask

  task automatic pulse_req(logic [N-1:0] bits);
    irq_req = irq_req | bits; tick(); irq_req = irq_req & ~bits;
  endtask

  task automatic ack();
    irq_ack = 1; tick(); irq_ack = 0;
  endtask

  task automatic ret();
    ret_stb = 1; tick(); ret_stb = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; irq_req = 0; irq_ack = 0; ret_stb = 0; cfg_we = 0;
    @(negedge clk); @(negedge clk);
    model_reset();
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // R10: reset state
    phase = "R10";
    #1 chk(cur_level == 5'd16 && nest_depth == 0 && pending == 0 && !stk_err,
           "R10 reset outputs", int'(cur_level), 16);
    idle(2);

    // R1: upper nibble only, lower value wins
    phase = "R1";
    cfg(2, 0, 4);
    cfg(0, 2, 1); cfg(0, 3, 1);
    cfg(1, 2, 8'h5A); cfg(1, 3, 8'h3F);
    pulse_req(16'h000C);
    #1 chk(irq_valid && irq_vec == 3, "R1 urgent line offered", int'(irq_vec), 3);
    ack();
    #1 chk(take_stb && take_vec == 3, "R1 take of line 3", int'(take_vec), 3);
    idle(1);
    ret(); ack(); idle(1); ret(); idle(1);

    // R4: full tie resolved by lowest index
    phase = "R4";
    cfg(0, 4, 1); cfg(0, 5, 1);
    cfg(1, 4, 8'h70); cfg(1, 5, 8'h70);
    pulse_req(16'h0030);
    #1 chk(irq_vec == 4, "R4 tie lowest index", int'(irq_vec), 4);
    ack(); ret(); ack(); ret(); idle(1);

    // R5: equal preemption field with better subpriority waits
    phase = "R5";
    cfg(2, 0, 2);
    cfg(0, 6, 1); cfg(0, 7, 1); cfg(0, 0, 1);
    cfg(1, 6, 8'h40); cfg(1, 7, 8'h70); cfg(1, 0, 8'h20);
    cfg(1, 5, 8'h50);
    pulse_req(16'h0080); ack(); idle(1);
    pulse_req(16'h0020);
    #1 chk(!irq_valid, "R5 equal field no nest", int'(irq_valid), 0);
    ret(); idle(1);
    ack(); idle(1);
    pulse_req(16'h0040);
    #1 chk(!irq_valid, "R5 same field waits", int'(irq_valid), 0);
    pulse_req(16'h0001);
    #1 chk(irq_valid && irq_vec == 0, "R5 lower field nests", int'(irq_vec), 0);
    // R7: nested return order
    phase = "R7";
    ack(); idle(1);
    ret();
    #1 chk(cur_level == 5'd4, "R7 level restored", int'(cur_level), 4);
    ret(); idle(1);
    ack(); ret(); idle(1);

    // R2: group split and illegal group write
    phase = "R2";
    cfg(2, 0, 4);
    cfg(0, 8, 1); cfg(0, 9, 1);
    cfg(1, 8, 8'hA0); cfg(1, 9, 8'hB0);
    pulse_req(16'h0100); ack(); idle(1);
    cfg(2, 0, 1);
    pulse_req(16'h0200);
    #1 chk(irq_valid && irq_vec == 9, "R2 group 1 lets 0xB preempt 0xA", int'(irq_valid), 1);
    cfg(2, 0, 6);
    #1 chk(irq_valid, "R2 group 6 ignored", int'(irq_valid), 1);
    ack(); ret(); ret(); idle(1);

    // R3: disabled line latches but never wins
    phase = "R3";
    cfg(2, 0, 4);
    cfg(0, 10, 0); cfg(1, 10, 8'h10);
    pulse_req(16'h0400);
    #1 chk(pending[10] && !irq_valid, "R3 disabled pending not offered", int'(irq_valid), 0);
    idle(2);
    cfg(0, 10, 1);
    #1 chk(irq_valid && irq_vec == 10, "R3 enabled line offered", int'(irq_vec), 10);
    ack(); ret(); idle(1);

    // R8: level hold, pulse edge, clear
    phase = "R8";
    cfg(0, 1, 1); cfg(1, 1, 8'h30);
    irq_req[1] = 1;
    tick();
    ack();
    #1 chk(pending[1], "R8 level held stays pending", int'(pending[1]), 1);
    ret();
    #1 chk(irq_valid && irq_vec == 1, "R8 reoffered after return", int'(irq_vec), 1);
    cfg(3, 1, 0);
    #1 chk(pending[1], "R8 set wins over clear", int'(pending[1]), 1);
    irq_req[1] = 0;
    cfg(3, 1, 0);
    #1 chk(!pending[1], "R8 clear after release", int'(pending[1]), 0);
    cfg(0, 11, 1); cfg(1, 11, 8'h60);
    irq_req[11] = 1;
    tick(); ack(); idle(2);
    #1 chk(!pending[11], "R8 pulse line edge only", int'(pending[11]), 0);
    irq_req[11] = 0;
    ret(); idle(1);

    // R11: return and ack together take nothing
    phase = "R11";
    cfg(0, 12, 1); cfg(1, 12, 8'h20);
    cfg(0, 13, 1); cfg(1, 13, 8'h10);
    pulse_req(16'h1000); ack(); idle(1);
    pulse_req(16'h2000);
    ret_stb = 1; irq_ack = 1;
    tick();
    ret_stb = 0; irq_ack = 0;
    #1 chk(!take_stb && pending[13] && nest_depth == 0, "R11 no take on return",
           int'(take_stb), 0);
    ack(); ret(); idle(1);

    // R9: underflow then overflow
    phase = "R9";
    ret();
    #1 chk(stk_err, "R9 underflow flag", int'(stk_err), 1);
    idle(2);
    do_reset();
    idle(1);
    cfg(2, 0, 4);
    for (int k = 0; k < 5; k++) begin
      cfg(0, 8 + k, 1);
      cfg(1, 8 + k, (10 - 2 * k) * 16);
    end
    for (int k = 0; k < 5; k++) begin
      pulse_req(N'(1) << (8 + k));
      ack();
    end
    #1 chk(stk_err && nest_depth == 3'd4, "R9 overflow flag depth kept", int'(nest_depth), 4);
    for (int k = 0; k < 4; k++) ret();
    #1 chk(cur_level == 5'd16, "R9 thread level after returns", int'(cur_level), 16);
    idle(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule